// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block divides the output of an external dual-modulus prescaler by a programmable ratio. It counts prescaler clocks with two down-counters: a main counter that sets the length of each division cycle, and a swallow counter that sets how many clocks at the start of that cycle the prescaler runs at its higher ratio. The modulus-control output tells the prescaler which ratio to use. With a prescaler ratio of P or P+1, a main ratio N and a swallow value A, the overall division from the oscillator to the divided pulse is N*P + A.

The ratios come from a latch that captures the input ratio buses when the load strobe is high at a clock edge. The counters read that latch only when a division cycle ends, so a ratio loaded mid-cycle never disturbs the cycle in progress. Out-of-range values are clamped at load time: a main ratio below 3 becomes 3, and a swallow value larger than the main ratio becomes the main ratio. Each division cycle produces one single-clock divided pulse for a phase detector.

Top module: `pswl_divider`

## Requirements
- R1: While reset is low and after its release, the divided pulse and the modulus control are inactive; the reset ratio is main 3, swallow 0, so the first pulse comes on the third rising edge after reset release.
- R2: With main ratio N latched, the divided pulse rises once every N clocks.
- R3: With swallow value A latched (A <= N), the modulus control is high for the first A clocks of each division cycle and low for the remaining N-A. The first clock of a cycle is the one in which the divided pulse is high.
- R4: The ratio inputs are captured only at a rising edge with the load strobe high; changes without the strobe have no effect on the cycle length or on the modulus control.
- R5: A ratio loaded during a cycle takes effect from the next cycle boundary; the cycle in progress keeps its old length and modulus-control pattern.
- R6: A main ratio of 0, 1 or 2 is latched as 3.
- R7: A swallow value greater than the main ratio is latched as the main ratio, so the modulus control stays high for the whole cycle.
- R8: A swallow value of 0 keeps the modulus control low for the whole cycle.
- R9: The full ranges work: main ratio 1023 and swallow value 127 give a 1023-clock cycle with 127 clocks of high modulus control.
- R10: The divided pulse is high for exactly one clock per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for the ratio inputs |
| main_ratio_i | input | 10 | Main ratio N, 3 to 1023 |
| swallow_i | input | 7 | Swallow value A, 0 to 127 |
| mod_ctrl_o | output | 1 | Modulus control, high selects the higher prescaler ratio |
| div_pulse_o | output | 1 | One-clock divided pulse per cycle |

## Verification
The ratio latch updates at the edge where the strobe is seen, and the counters use it at the first cycle boundary after that; the divided pulse rises at the edge that ends the N-th clock of a cycle, and the modulus control follows the swallow count with no further register, so it is valid from the same edge that starts the cycle. The bench keeps a behavioural model that advances its cycle position at every rising edge and applies pending ratios only at its own boundary. Both outputs are compared against it at every falling edge. Directed checks measure whole cycles, pulse to pulse. Each one starts only after a full boundary has passed since the load, so that a load landing on a boundary edge cannot make the expected values ambiguous.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
   // Polarity of the modulus-control output
   typedef enum logic {
      MC_ACTIVE_HIGH = 1'b0,
      MC_ACTIVE_LOW  = 1'b1
   } mc_pol_e;

   // Smallest main ratio the counters support
   localparam int PSWL_MIN_MAIN = 3;
endpackage

// File: rtl/pswl_ratio_latch.sv
module pswl_ratio_latch #(
   parameter int MAIN_W   = 10,
   parameter int SWAL_W   = 7,
   parameter int MIN_MAIN = pswl_pkg::PSWL_MIN_MAIN,
   parameter int RST_MAIN = pswl_pkg::PSWL_MIN_MAIN,
   parameter int RST_SWAL = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [MAIN_W-1:0] main_in_i,
   input  logic [SWAL_W-1:0] swal_in_i,
   output logic [MAIN_W-1:0] main_q_o,
   output logic [SWAL_W-1:0] swal_q_o
);
   localparam logic [MAIN_W-1:0] MIN_V      = MAIN_W'(MIN_MAIN);
   localparam logic [MAIN_W-1:0] RST_MAIN_V = MAIN_W'(RST_MAIN);
   localparam logic [SWAL_W-1:0] RST_SWAL_V = SWAL_W'(RST_SWAL);

   logic [MAIN_W-1:0] main_c;
   logic [MAIN_W-1:0] swal_ext;
   logic [SWAL_W-1:0] swal_c;

   // Clamp at capture time so the counters never see an illegal pair
   always_comb begin
      main_c   = (main_in_i < MIN_V) ? MIN_V : main_in_i;
      swal_ext = MAIN_W'(swal_in_i);
      swal_c   = (swal_ext > main_c) ? SWAL_W'(main_c) : swal_in_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         main_q_o <= RST_MAIN_V;
         swal_q_o <= RST_SWAL_V;
      end else if (load_i) begin
         main_q_o <= main_c;
         swal_q_o <= swal_c;
      end
   end

   assert_main_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      main_q_o >= MIN_V);

   assert_swal_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      MAIN_W'(swal_q_o) <= main_q_o);

   assert_hold_no_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> ($stable(main_q_o) && $stable(swal_q_o)));
endmodule

// File: rtl/pswl_main_ctr.sv
module pswl_main_ctr #(
   parameter int MAIN_W   = 10,
   parameter int RST_MAIN = pswl_pkg::PSWL_MIN_MAIN
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [MAIN_W-1:0] reload_i,
   output logic [MAIN_W-1:0] cnt_o,
   output logic              wrap_o
);
   localparam logic [MAIN_W-1:0] ONE_V = MAIN_W'(1);

   // Counts N down to 1; the state holding 1 is the last clock of a cycle
   assign wrap_o = (cnt_o == ONE_V);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_o <= MAIN_W'(RST_MAIN);
      else if (wrap_o) cnt_o <= reload_i;
      else             cnt_o <= cnt_o - ONE_V;
   end

   assert_never_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o != '0);

   assert_no_midcycle_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_o |=> (cnt_o == $past(cnt_o) - ONE_V));
endmodule

// File: rtl/pswl_swallow_ctr.sv
module pswl_swallow_ctr #(
   parameter int SWAL_W   = 7,
   parameter int RST_SWAL = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wrap_i,
   input  logic [SWAL_W-1:0] reload_i,
   output logic [SWAL_W-1:0] cnt_o,
   output logic              busy_o
);
   localparam logic [SWAL_W-1:0] ONE_V = SWAL_W'(1);

   assign busy_o = (cnt_o != '0);

   // Reloads with the main counter, then runs down and parks at zero
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_o <= SWAL_W'(RST_SWAL);
      else if (wrap_i)  cnt_o <= reload_i;
      else if (busy_o)  cnt_o <= cnt_o - ONE_V;
   end

   assert_swal_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wrap_i && busy_o) |=> (cnt_o == $past(cnt_o) - ONE_V));

   assert_swal_parks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wrap_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
   parameter int               MAIN_W   = 10,
   parameter int               SWAL_W   = 7,
   parameter int               MIN_MAIN = pswl_pkg::PSWL_MIN_MAIN,
   parameter int               RST_MAIN = pswl_pkg::PSWL_MIN_MAIN,
   parameter int               RST_SWAL = 0,
   parameter pswl_pkg::mc_pol_e MC_POL  = pswl_pkg::MC_ACTIVE_HIGH
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [MAIN_W-1:0] main_ratio_i,
   input  logic [SWAL_W-1:0] swallow_i,
   output logic              mod_ctrl_o,
   output logic              div_pulse_o
);
   // Elaboration-time parameter checks
   if (MAIN_W < 2) begin : g_bad_main_w
      $error("pswl_divider: MAIN_W must be at least 2");
   end
   if (SWAL_W < 1 || SWAL_W > MAIN_W) begin : g_bad_swal_w
      $error("pswl_divider: SWAL_W must lie in 1..MAIN_W");
   end
   if (MIN_MAIN < 2 || MIN_MAIN >= (1 << MAIN_W)) begin : g_bad_min
      $error("pswl_divider: MIN_MAIN out of range");
   end
   if (RST_MAIN < MIN_MAIN || RST_MAIN >= (1 << MAIN_W)) begin : g_bad_rst_main
      $error("pswl_divider: RST_MAIN out of range");
   end
   if (RST_SWAL < 0 || RST_SWAL > RST_MAIN || RST_SWAL >= (1 << SWAL_W)) begin : g_bad_rst_swal
      $error("pswl_divider: RST_SWAL out of range");
   end

   logic [MAIN_W-1:0] main_lat;
   logic [SWAL_W-1:0] swal_lat;
   logic [MAIN_W-1:0] main_cnt;
   logic [SWAL_W-1:0] swal_cnt;
   logic              wrap;
   logic              swal_busy;
   logic              pulse_q;

   pswl_ratio_latch #(
      .MAIN_W  (MAIN_W),
      .SWAL_W  (SWAL_W),
      .MIN_MAIN(MIN_MAIN),
      .RST_MAIN(RST_MAIN),
      .RST_SWAL(RST_SWAL)
   ) u_latch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .main_in_i(main_ratio_i),
      .swal_in_i(swallow_i),
      .main_q_o (main_lat),
      .swal_q_o (swal_lat)
   );

   pswl_main_ctr #(
      .MAIN_W  (MAIN_W),
      .RST_MAIN(RST_MAIN)
   ) u_main (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .reload_i(main_lat),
      .cnt_o   (main_cnt),
      .wrap_o  (wrap)
   );

   pswl_swallow_ctr #(
      .SWAL_W  (SWAL_W),
      .RST_SWAL(RST_SWAL)
   ) u_swal (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wrap_i  (wrap),
      .reload_i(swal_lat),
      .cnt_o   (swal_cnt),
      .busy_o  (swal_busy)
   );

   // Divided pulse marks the first clock of each new cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= wrap;
   end
   assign div_pulse_o = pulse_q;

   // Modulus control straight from the swallow flop: clock-to-out only
   if (MC_POL == pswl_pkg::MC_ACTIVE_HIGH) begin : g_mc_high
      assign mod_ctrl_o = swal_busy;
   end else begin : g_mc_low
      assign mod_ctrl_o = ~swal_busy;
   end

   assert_pulse_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_pulse_o |=> !div_pulse_o);

   assert_swal_within_main_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      MAIN_W'(swal_cnt) <= main_cnt);

   assert_pulse_after_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_pulse_o) |-> ($past(main_cnt) == MAIN_W'(1)));
endmodule

// File: tb/pswl_divider_bench.sv
module pswl_divider_bench;
   localparam int MW = 10;
   localparam int SW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load = 1'b0;
   logic [MW-1:0] main_r = '0;
   logic [SW-1:0] swal_r = '0;
   logic          mc;
   logic          pulse;

   always #5 clk = ~clk;

   pswl_divider u_pswl_divider (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .load_i      (load),
      .main_ratio_i(main_r),
      .swallow_i   (swal_r),
      .mod_ctrl_o  (mc),
      .div_pulse_o (pulse)
   );

   int    vectors = 0;
   int    fails = 0;
   bit    done = 0;
   string tag = "R1";

   // Behavioural reference: position in cycle plus current and pending ratios
   int k, cur_n, cur_a, pend_n, pend_a;
   bit exp_pulse;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k = 0; cur_n = 3; cur_a = 0; pend_n = 3; pend_a = 0; exp_pulse = 0;
      end else begin
         if (k == cur_n - 1) begin
            k = 0; cur_n = pend_n; cur_a = pend_a; exp_pulse = 1;
         end else begin
            k = k + 1; exp_pulse = 0;
         end
         if (load) begin
            pend_n = (int'(main_r) < 3) ? 3 : int'(main_r);
            pend_a = (int'(swal_r) > pend_n) ? pend_n : int'(swal_r);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         vectors++;
         if (pulse !== exp_pulse || mc !== (k < cur_a)) begin
            fails++;
            $display("FAIL %s: pulse=%b mc=%b expected pulse=%b mc=%b",
                     tag, pulse, mc, exp_pulse, (k < cur_a));
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_ratio(input int n, input int a);
      @(negedge clk);
      main_r = MW'(n); swal_r = SW'(a); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!pulse);
   endtask

   // Measure one full cycle starting at the next pulse
   task automatic measure(input int exp_n, input int exp_a, input string req);
      int len = 0;
      int hi = 0;
      wait_pulse();
      do begin
         if (mc) hi++;
         len++;
         @(negedge clk);
      end while (!pulse);
      chk(req, len, exp_n);
      chk(req, hi, exp_a);
   endtask

   task automatic settle(input int n, input int a);
      load_ratio(n, a);
      wait_pulse();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle in reset
      chk("R1", int'(pulse), 0);
      chk("R1", int'(mc), 0);
      rst_n = 1'b1;
      // R1: first pulse on third rising edge after release
      begin
         int n = 0;
         do begin n++; @(negedge clk); end while (!pulse && n < 10);
         chk("R1", n, 3);
      end
      measure(3, 0, "R1");

      tag = "R2"; settle(5, 2); measure(5, 2, "R2");
      tag = "R3"; settle(9, 4); measure(9, 4, "R3");

      // R5: load just after a boundary, current cycle keeps old ratio
      tag = "R5"; settle(8, 3);
      wait_pulse();
      begin
         int len = 0;
         int hi = 0;
         main_r = 10'd4; swal_r = 7'd1; load = 1'b1;
         do begin
            if (mc) hi++;
            len++;
            @(negedge clk);
            load = 1'b0;
         end while (!pulse);
         chk("R5", len, 8);
         chk("R5", hi, 3);
      end
      measure(4, 1, "R5");

      // R4: inputs change without the strobe
      tag = "R4";
      main_r = 10'd20; swal_r = 7'd5;
      measure(4, 1, "R4");
      measure(4, 1, "R4");

      tag = "R6"; settle(1, 0); measure(3, 0, "R6");
      settle(0, 2); measure(3, 2, "R6");
      settle(2, 5); measure(3, 3, "R6");
      tag = "R7"; settle(4, 9); measure(4, 4, "R7");
      tag = "R8"; settle(12, 0); measure(12, 0, "R8");
      tag = "R9"; settle(1023, 127); measure(1023, 127, "R9");
      tag = "R10"; settle(3, 3); measure(3, 3, "R10");

      // R2, R3, R5: random loads at random times, checked by the model
      tag = "R2_R3_R5 random";
      for (int i = 0; i < 40; i++) begin
         load_ratio($urandom_range(0, 40), $urandom_range(0, 45));
         repeat ($urandom_range(1, 60)) @(negedge clk);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule